// File: doc/BRIEF.md
# Interleaved Deblocking Edge Scheduler

This block sequences the edge operations of a deblocking filter that works on 4x4 pixel blocks. For each macroblock it issues one command per block edge to an edge-filter datapath. A luma macroblock is a 4x4 grid of blocks. A chroma block is a 2x2 grid. Each command names the following:

- the block position;
- whether the edge is vertical or horizontal;
- where the p-side and q-side samples are read from: the current-macroblock memory, the neighbour memory, or one of four 4x4 buffer slots;
- where each side's filtered result is written back.

The ordering interleaves the two edge directions. A block is finished while it is still held in the buffer, so it does not have to be read back for a second pass. The result must still equal an all-vertical-then-all-horizontal pass. To achieve this, every horizontal edge is issued only after every vertical edge that touches its pixels.

A macroblock starts with a one-cycle `start_i`. The `chroma_i` input is sampled with it and selects the grid. Commands leave on a valid/ready handshake. A luma macroblock is processed as an upper part (block rows 0–1) and then a lower part (block rows 2–3), each part taking eight time instances. A chroma block is a single part of four instances. Within a part, instances visit block positions column by column, taking the top row before the bottom row of each column.

The controller is a state machine with five states:

- **IDLE**: waits; IDLE → VERT on `start_i`.
- **VERT**: left edge of the current block.
  - VERT → HPREV on acceptance when the column is not 0.
  - Otherwise on acceptance: VERT → VERT if another instance follows, or VERT → DONE after the last instance.
- **HPREV**: top edge of the block one column to the left.
  - HPREV → HOWN on acceptance in the last column.
  - Otherwise on acceptance: HPREV → VERT if another instance follows, or HPREV → DONE after the last instance.
- **HOWN**: top edge of the current block, used in the last column only.
  - On acceptance: HOWN → VERT if another instance follows, or HOWN → DONE after the last instance.
- **DONE**: one cycle, then DONE → IDLE.

Top module: `dbf_edge_sched`

## Requirements
- R1: While reset is held and afterwards until a start, `cmd_valid_o`, `busy_o` and `done_o` are 0.
- R2: A luma macroblock yields 32 commands over 16 instances. The instance number `cmd_inst_o` runs 0..15, with instance = part*8 + col*2 + rowInPart, where part 0 covers rows 0–1 and part 1 covers rows 2–3.
- R3: In the instance for block (c,r), the commands are issued in this order:
  - first, the vertical edge on the left of (c,r);
  - then, if c>0, the horizontal edge on top of (c-1,r);
  - then, in the last column, the horizontal edge on top of (c,r).
  
  As a result, a horizontal edge always follows every vertical edge of the two block columns and two block rows it touches, and it follows the horizontal edge above it.
- R4: Within one macroblock every edge is issued exactly once: 16 vertical and 16 horizontal edges for luma, 4 and 4 for chroma.
- R5: With `chroma_i`=1 at start, the grid is 2x2 blocks in a single part of 4 instances (instance = col*2 + row), giving 8 commands in the R3 order.
- R6: Location codes are 0 for current-macroblock memory, 1 for neighbour memory, and 4+slot for buffer slots, with slot = 2*col[0] + row[0]. For a vertical edge of block (c,r):
  - p is read from the neighbour memory when c=0, and otherwise from the left block's slot;
  - p is written back to the same place it was read from;
  - q is read from the current-macroblock memory and written to the slot of (c,r).
- R7: For a horizontal edge of block (c,r), the routing depends on the row within the part.
  - First row of the part: p is read from and written to the neighbour memory in the upper part or chroma, and the current-macroblock memory in the lower part; q is read from and written to the slot of (c,r).
  - Second row of the part: p is read from the slot of the block above and q from its own slot, and both are written to the current-macroblock memory.
- R8: Every read names the place where that block's latest data lives. No slot is overwritten while it holds live data of another block. At the end of a macroblock every block is back in the current-macroblock memory.
- R9: While `cmd_valid_o`=1 and `cmd_ready_i`=0, the command stays valid and all of its fields stay unchanged.
- R10: `done_o` is high for exactly the one cycle after the last command is accepted, and `busy_o` is 0 afterwards.
- R11: A `start_i` pulse while busy is ignored. The command stream, including the grid chosen by `chroma_i`, is unchanged.
- R12: The p-side and q-side read locations of a command always differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts one macroblock when idle |
| chroma_i | input | 1 | Sampled with start: 1 selects the 2x2 chroma grid |
| cmd_ready_i | input | 1 | Edge filter accepts the current command |
| busy_o | output | 1 | A macroblock is in progress |
| done_o | output | 1 | One-cycle pulse after the last command is accepted |
| cmd_valid_o | output | 1 | A command is presented |
| cmd_horiz_o | output | 1 | 0 for a vertical (left) edge, 1 for a horizontal (top) edge |
| cmd_col_o | output | 2 | Block column of the q-side block |
| cmd_row_o | output | 2 | Block row of the q-side block |
| cmd_inst_o | output | 4 | Time instance number |
| cmd_psrc_o | output | 3 | p-side read location |
| cmd_qsrc_o | output | 3 | q-side read location |
| cmd_pdst_o | output | 3 | p-side write-back location |
| cmd_qdst_o | output | 3 | q-side write-back location |

## Verification
The assertions check the following on every cycle:

- commands are held during stalls;
- the done pulse is single and directly follows an acceptance;
- p and q never read the same location;
- the instance number stays inside the grid;
- the part stays at zero for chroma;
- the controller is quiet while idle.

The bench scenarios cover what a single cycle cannot show. They compare the full command order against the expected list. They keep a per-block record of applied edges that flags a horizontal edge issued ahead of a vertical edge on its pixels, as well as repeated or missing edges. They model where each block's data lives, so that a stale read or a clobbered slot is caught. This is repeated under several stall patterns and with a start pulse arriving mid-macroblock.

// File: rtl/dbf_sched_pkg.sv
package dbf_sched_pkg;

    // Geometry of the block grids (blocks per side)
    localparam int LUMA_BLK   = 4;
    localparam int CHROMA_BLK = 2;
    localparam int COL_W      = $clog2(LUMA_BLK);
    localparam int PART_W     = COL_W - 1;
    localparam int INST_W     = 2 * COL_W;
    localparam int LOC_W      = 3;

    typedef logic [LOC_W-1:0] loc_t;

    localparam loc_t LOC_CUR = 3'd0;
    localparam loc_t LOC_NBR = 3'd1;

    // Buffer slot code: 4 + 2*col[0] + rowInPart
    function automatic loc_t buf_loc(input logic col_lsb, input logic sub);
        return {1'b1, col_lsb, sub};
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VERT,
        ST_HPREV,
        ST_HOWN,
        ST_DONE
    } state_t;

    typedef enum logic [1:0] {
        EK_VERT,
        EK_HPREV,
        EK_HOWN
    } edge_kind_t;

    typedef struct packed {
        logic             horiz;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] row;
        loc_t             psrc;
        loc_t             qsrc;
        loc_t             pdst;
        loc_t             qdst;
    } edge_cmd_t;

endpackage

// File: rtl/dbf_inst_walker.sv
module dbf_inst_walker
    import dbf_sched_pkg::*;
#(
    parameter int LUMA_N   = LUMA_BLK,
    parameter int CHROMA_N = CHROMA_BLK
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        init_i,
    input  logic                        step_i,
    input  logic                        chroma_i,
    output logic [$clog2(LUMA_N)-1:0]   col_o,
    output logic                        sub_o,
    output logic [$clog2(LUMA_N)-2:0]   part_o,
    output logic                        last_col_o,
    output logic                        last_inst_o,
    output logic [2*$clog2(LUMA_N)-1:0] inst_o
);

    localparam int CW = $clog2(LUMA_N);
    localparam int PW = CW - 1;
    localparam logic [CW-1:0] LUMA_LAST   = CW'(LUMA_N - 1);
    localparam logic [CW-1:0] CHROMA_LAST = CW'(CHROMA_N - 1);
    localparam logic [PW-1:0] PART_LAST   = {PW{1'b1}};

    logic [CW-1:0] col_q;
    logic          sub_q;
    logic [PW-1:0] part_q;
    logic          last_part_w;

    // Position counter: row within part, then column, then part
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            sub_q  <= 1'b0;
            part_q <= '0;
        end else if (init_i) begin
            col_q  <= '0;
            sub_q  <= 1'b0;
            part_q <= '0;
        end else if (step_i) begin
            if (!sub_q) begin
                sub_q <= 1'b1;
            end else begin
                sub_q <= 1'b0;
                if (last_col_o) begin
                    col_q  <= '0;
                    part_q <= part_q + PW'(1);
                end else begin
                    col_q <= col_q + CW'(1);
                end
            end
        end
    end

    always_comb begin
        last_col_o  = (col_q == (chroma_i ? CHROMA_LAST : LUMA_LAST));
        last_part_w = chroma_i || (part_q == PART_LAST);
        last_inst_o = last_col_o && sub_q && last_part_w;
        inst_o      = {part_q, col_q, sub_q};
        col_o       = col_q;
        sub_o       = sub_q;
        part_o      = part_q;
    end

    AST_COL_IN_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (col_q <= (chroma_i ? CHROMA_LAST : LUMA_LAST))); // R5
    AST_CHROMA_ONE_PART: assert property (@(posedge clk) disable iff (!rst_n)
        (chroma_i && step_i) |-> (part_q == '0)); // R5

endmodule

// File: rtl/dbf_edge_route.sv
module dbf_edge_route
    import dbf_sched_pkg::*;
(
    input  edge_kind_t        kind_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              sub_i,
    input  logic [PART_W-1:0] part_i,
    output edge_cmd_t         cmd_o
);

    logic [COL_W-1:0] edge_col;
    logic [COL_W-1:0] left_col;
    logic             upper_part;

    always_comb begin
        left_col   = col_i - COL_W'(1);
        edge_col   = (kind_i == EK_HPREV) ? left_col : col_i;
        upper_part = (part_i == '0);

        cmd_o      = '0;
        cmd_o.col  = edge_col;
        cmd_o.row  = {part_i, sub_i};

        unique case (kind_i)
            EK_VERT: begin
                // left edge: p from the left block, q is fetched fresh
                cmd_o.horiz = 1'b0;
                cmd_o.psrc  = (col_i == '0) ? LOC_NBR : buf_loc(left_col[0], sub_i);
                cmd_o.pdst  = cmd_o.psrc;
                cmd_o.qsrc  = LOC_CUR;
                cmd_o.qdst  = buf_loc(col_i[0], sub_i);
            end
            default: begin
                // top edge of block edge_col
                cmd_o.horiz = 1'b1;
                if (!sub_i) begin
                    cmd_o.psrc = upper_part ? LOC_NBR : LOC_CUR;
                    cmd_o.pdst = cmd_o.psrc;
                    cmd_o.qsrc = buf_loc(edge_col[0], 1'b0);
                    cmd_o.qdst = cmd_o.qsrc;
                end else begin
                    // both blocks of the column complete for this part
                    cmd_o.psrc = buf_loc(edge_col[0], 1'b0);
                    cmd_o.qsrc = buf_loc(edge_col[0], 1'b1);
                    cmd_o.pdst = LOC_CUR;
                    cmd_o.qdst = LOC_CUR;
                end
            end
        endcase
    end

endmodule

// File: rtl/dbf_edge_sched.sv
module dbf_edge_sched
    import dbf_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              chroma_i,
    input  logic              cmd_ready_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              cmd_valid_o,
    output logic              cmd_horiz_o,
    output logic [COL_W-1:0]  cmd_col_o,
    output logic [COL_W-1:0]  cmd_row_o,
    output logic [INST_W-1:0] cmd_inst_o,
    output logic [LOC_W-1:0]  cmd_psrc_o,
    output logic [LOC_W-1:0]  cmd_qsrc_o,
    output logic [LOC_W-1:0]  cmd_pdst_o,
    output logic [LOC_W-1:0]  cmd_qdst_o
);

    state_t            state_q, state_d;
    logic              chroma_q;
    logic              init_w, step_w, accept_w;
    edge_kind_t        kind_w;
    edge_cmd_t         cmd_w;
    logic [COL_W-1:0]  walk_col;
    logic              walk_sub;
    logic [PART_W-1:0] walk_part;
    logic              walk_last_col, walk_last_inst;
    logic [INST_W-1:0] walk_inst;

    dbf_inst_walker #(
        .LUMA_N   (LUMA_BLK),
        .CHROMA_N (CHROMA_BLK)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_w),
        .step_i      (step_w),
        .chroma_i    (chroma_q),
        .col_o       (walk_col),
        .sub_o       (walk_sub),
        .part_o      (walk_part),
        .last_col_o  (walk_last_col),
        .last_inst_o (walk_last_inst),
        .inst_o      (walk_inst)
    );

    dbf_edge_route u_route (
        .kind_i (kind_w),
        .col_i  (walk_col),
        .sub_i  (walk_sub),
        .part_i (walk_part),
        .cmd_o  (cmd_w)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Grid selection captured at start only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           chroma_q <= 1'b0;
        else if (state_q == ST_IDLE && start_i) chroma_q <= chroma_i;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        init_w  = 1'b0;
        step_w  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_VERT;
                    init_w  = 1'b1;
                end
            end
            ST_VERT: begin
                if (accept_w) begin
                    if (walk_col != '0) begin
                        state_d = ST_HPREV;
                    end else if (walk_last_inst) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_VERT;
                        step_w  = 1'b1;
                    end
                end
            end
            ST_HPREV: begin
                if (accept_w) begin
                    if (walk_last_col) begin
                        state_d = ST_HOWN;
                    end else if (walk_last_inst) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_VERT;
                        step_w  = 1'b1;
                    end
                end
            end
            ST_HOWN: begin
                if (accept_w) begin
                    if (walk_last_inst) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_VERT;
                        step_w  = 1'b1;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_valid_o = 1'b0;
        busy_o      = 1'b1;
        done_o      = 1'b0;
        kind_w      = EK_VERT;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_VERT:  begin cmd_valid_o = 1'b1; kind_w = EK_VERT;  end
            ST_HPREV: begin cmd_valid_o = 1'b1; kind_w = EK_HPREV; end
            ST_HOWN:  begin cmd_valid_o = 1'b1; kind_w = EK_HOWN;  end
            ST_DONE:  done_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
        accept_w    = cmd_valid_o && cmd_ready_i;
        cmd_horiz_o = cmd_w.horiz;
        cmd_col_o   = cmd_w.col;
        cmd_row_o   = cmd_w.row;
        cmd_inst_o  = walk_inst;
        cmd_psrc_o  = cmd_w.psrc;
        cmd_qsrc_o  = cmd_w.qsrc;
        cmd_pdst_o  = cmd_w.pdst;
        cmd_qdst_o  = cmd_w.qdst;
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_w) && $stable(cmd_inst_o))); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(cmd_valid_o && cmd_ready_i)); // R10
    AST_PQ_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_psrc_o != cmd_qsrc_o)); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cmd_valid_o && !done_o)); // R1
    AST_INST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (int'(cmd_inst_o) < (chroma_q ? CHROMA_BLK*CHROMA_BLK : LUMA_BLK*LUMA_BLK))); // R2

endmodule

// File: tb/test_dbf_edge_sched.sv
`timescale 1ns/1ps
module test_dbf_edge_sched;

    logic clk = 1'b0;
    logic rst_n, start_i, chroma_i, cmd_ready_i;
    logic busy_o, done_o, cmd_valid_o, cmd_horiz_o;
    logic [1:0] cmd_col_o, cmd_row_o;
    logic [3:0] cmd_inst_o;
    logic [2:0] cmd_psrc_o, cmd_qsrc_o, cmd_pdst_o, cmd_qdst_o;

    initial forever #4 clk = ~clk;

    dbf_edge_sched i_dbf_edge_sched (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chroma_i(chroma_i),
        .cmd_ready_i(cmd_ready_i), .busy_o(busy_o), .done_o(done_o),
        .cmd_valid_o(cmd_valid_o), .cmd_horiz_o(cmd_horiz_o),
        .cmd_col_o(cmd_col_o), .cmd_row_o(cmd_row_o), .cmd_inst_o(cmd_inst_o),
        .cmd_psrc_o(cmd_psrc_o), .cmd_qsrc_o(cmd_qsrc_o),
        .cmd_pdst_o(cmd_pdst_o), .cmd_qdst_o(cmd_qdst_o)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    typedef logic [20:0] pack_t;   // horiz,col,row,inst,psrc,qsrc,pdst,qdst
    pack_t sbq[$];

    int  loc[16];
    int  slot_own[4];
    bit  vdone[4][4];
    bit  hdone[4][4];
    int  mb_n = 4;
    int  stall_mode = 0;
    logic [7:0] lfsr = 8'hA5;
    int  cyc3 = 0;
    bit  held_valid = 1'b0;
    pack_t held_pack;
    bit  done_due = 1'b0;
    bit  mb_complete = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bufl(input int c, input int s);
        return 4 + (c % 2) * 2 + s;
    endfunction

    function automatic pack_t mk(input bit h, input int c, input int r, input int inst,
                                 input int ps, input int qs, input int pd, input int qd);
        return {h, 2'(c), 2'(r), 4'(inst), 3'(ps), 3'(qs), 3'(pd), 3'(qd)};
    endfunction

    function automatic pack_t cur_pack();
        return {cmd_horiz_o, cmd_col_o, cmd_row_o, cmd_inst_o,
                cmd_psrc_o, cmd_qsrc_o, cmd_pdst_o, cmd_qdst_o};
    endfunction

    // Driver: expected stream from R2/R3/R5/R6/R7
    task automatic push_horiz(input int ec, input int r, input int s, input int p, input int inst);
        if (s == 0) begin
            int ps = (p == 0) ? 1 : 0;
            sbq.push_back(mk(1, ec, r, inst, ps, bufl(ec, 0), ps, bufl(ec, 0)));
        end else begin
            sbq.push_back(mk(1, ec, r, inst, bufl(ec, 0), bufl(ec, 1), 0, 0));
        end
    endtask

    task automatic push_mb(input bit chroma);
        int parts = chroma ? 1 : 2;
        mb_n = chroma ? 2 : 4;
        for (int i = 0; i < 16; i++) loc[i] = 0;
        for (int i = 0; i < 4; i++) slot_own[i] = -1;
        for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) begin
            vdone[i][j] = 0; hdone[i][j] = 0;
        end
        for (int p = 0; p < parts; p++)
            for (int c = 0; c < mb_n; c++)
                for (int s = 0; s < 2; s++) begin
                    int r    = p * 2 + s;
                    int inst = p * 2 * mb_n + c * 2 + s;
                    int ps   = (c == 0) ? 1 : bufl(c - 1, s);
                    sbq.push_back(mk(0, c, r, inst, ps, 0, ps, bufl(c, s)));
                    if (c > 0)        push_horiz(c - 1, r, s, p, inst);
                    if (c == mb_n-1)  push_horiz(c, r, s, p, inst);
                end
    endtask

    task automatic apply_loc(input int id, input int dst);
        int old = loc[id];
        if (dst >= 4) begin
            int o = slot_own[dst-4];
            chk(!(o >= 0 && o != id && loc[o] == dst), "R8", "live slot overwritten", o, id);
        end
        if (old >= 4 && old != dst && slot_own[old-4] == id) slot_own[old-4] = -1;
        if (dst >= 4) slot_own[dst-4] = id;
        loc[id] = dst;
    endtask

    task automatic accept_cmd();
        int c = int'(cmd_col_o);
        int r = int'(cmd_row_o);
        bit h = cmd_horiz_o;
        bit pnbr;
        int pid, qid;
        pack_t e;
        if (sbq.size() == 0) begin
            chk(0, "R4", "command after end of macroblock", cur_pack(), 0);
            return;
        end
        e = sbq.pop_front();
        chk(cur_pack() == e, h ? "R7" : "R6", "command fields (R2/R3 order)", cur_pack(), e);
        // per-block edge record
        if (!h) begin
            chk(!vdone[r][c], "R4", "vertical edge repeated", r*4+c, 0);
            if (c > 0) chk(vdone[r][c-1], "R3", "vertical edges out of order", c, c-1);
            vdone[r][c] = 1;
        end else begin
            chk(!hdone[r][c], "R4", "horizontal edge repeated", r*4+c, 0);
            for (int rr = r - 1; rr <= r; rr++)
                for (int cc = c; cc <= c + 1; cc++)
                    if (rr >= 0 && cc < mb_n)
                        chk(vdone[rr][cc], "R3", "horizontal before vertical on shared pixels", rr*4+cc, 1);
            if (r > 0) chk(hdone[r-1][c], "R3", "horizontal edges out of row order", r, r-1);
            hdone[r][c] = 1;
        end
        // data location model
        pnbr = h ? (r == 0) : (c == 0);
        pid  = h ? (r - 1) * 4 + c : r * 4 + c - 1;
        qid  = r * 4 + c;
        chk(int'(cmd_psrc_o) == (pnbr ? 1 : loc[pid]), "R8", "p read location", cmd_psrc_o, pnbr ? 1 : loc[pid]);
        chk(int'(cmd_qsrc_o) == loc[qid], "R8", "q read location", cmd_qsrc_o, loc[qid]);
        chk(cmd_psrc_o != cmd_qsrc_o, "R12", "p and q share a location", cmd_psrc_o, cmd_qsrc_o);
        if (!pnbr) apply_loc(pid, int'(cmd_pdst_o));
        apply_loc(qid, int'(cmd_qdst_o));
        if (sbq.size() == 0) begin
            done_due = 1'b1;
            for (int rr = 0; rr < mb_n; rr++)
                for (int cc = 0; cc < mb_n; cc++) begin
                    chk(vdone[rr][cc] && hdone[rr][cc], "R4", "edge missing at end", rr*4+cc, 1);
                    chk(loc[rr*4+cc] == 0, "R8", "block not written back", loc[rr*4+cc], 0);
                end
        end
    endtask

    // Monitor and ready generator
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            case (stall_mode)
                0: cmd_ready_i = 1'b1;
                1: begin
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    cmd_ready_i = lfsr[0];
                end
                default: begin
                    cyc3 = (cyc3 + 1) % 3;
                    cmd_ready_i = (cyc3 == 0);
                end
            endcase
            if (held_valid)
                chk(cmd_valid_o && cur_pack() == held_pack, "R9", "command changed while stalled", cur_pack(), held_pack);
            held_valid = cmd_valid_o && !cmd_ready_i;
            held_pack  = cur_pack();
            chk(done_o == done_due, "R10", "done pulse", done_o, done_due);
            if (done_due) mb_complete = 1'b1;
            done_due = 1'b0;
            if (cmd_valid_o && cmd_ready_i) accept_cmd();
        end
    end

    task automatic run_mb(input bit chroma, input int mode, input bit poke);
        push_mb(chroma);
        stall_mode = mode;
        mb_complete = 1'b0;
        @(negedge clk);
        start_i = 1'b1; chroma_i = chroma;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R11: start with the other grid while busy must be ignored
            repeat (4) @(negedge clk);
            chk(busy_o, "R11", "busy before poke", busy_o, 1);
            start_i = 1'b1; chroma_i = !chroma;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!mb_complete) @(negedge clk);
        @(negedge clk);
        chk(!busy_o && !cmd_valid_o, "R10", "idle after done", busy_o, 0);
        chk(sbq.size() == 0, chroma ? "R5" : "R2", "commands left over", sbq.size(), 0);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(0, "R1", "watchdog expired", 0, 1);
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; chroma_i = 1'b0; cmd_ready_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!cmd_valid_o && !busy_o && !done_o, "R1", "reset outputs",
                {cmd_valid_o, busy_o, done_o}, 0);
        end
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(!cmd_valid_o && !busy_o && !done_o, "R1", "idle before start",
                {cmd_valid_o, busy_o, done_o}, 0);
        end
        run_mb(0, 0, 0);   // R2 luma, never stalled
        run_mb(0, 1, 0);   // R9 luma, random stalls
        run_mb(1, 0, 0);   // R5 chroma
        run_mb(1, 1, 0);   // R5 chroma, random stalls
        run_mb(0, 2, 0);   // luma, ready one cycle in three
        run_mb(0, 0, 1);   // R11 luma with start while busy
        run_mb(1, 2, 1);   // R11 chroma with start while busy
        run_mb(0, 1, 0);   // back to luma after chroma
        summary();
    end

endmodule